// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block is a synchronous controller for an array of asynchronous fast page mode DRAM that is 32 bits wide and holds 4M words. A client issues single-word read or write requests with a 22-bit word address and a 4-bit byte-enable. The controller splits the address into an 11-bit row (upper bits) and an 11-bit column (lower bits) and drives them in turn on a shared 11-bit address bus. It drives two row strobes, four byte-lane column strobes, a write strobe and a data-bus output enable. The unit of timing is one controller clock, and every minimum interval is a whole number of cycles.

After an access the row stays open. When the next request falls in the same row, the controller runs only a column cycle (a page hit). A different row first closes the open one and waits out the precharge. A refresh request closes any open row, runs a column-before-row refresh cycle and answers with a one-cycle acknowledge. A row-low timer closes the row before the maximum row-strobe width runs out, even while page hits keep arriving.

The FSM has these states. IDLE waits for work and keeps the row strobe low while a row is open. PRECHG holds the row strobe high for T_RP cycles. ROWACT drops the row strobe, drives the row and then the column, for T_RCD cycles. COLACC holds the column strobes low for T_CAS cycles. COLPRE holds them high for T_CP cycles. REFCAS drops all column strobes with the row strobe high. REFRAS then drops the row strobe for T_REF cycles.

The transitions are these. IDLE goes to REFCAS on a refresh with the row closed, or to PRECHG on a refresh with a row open. IDLE goes to ROWACT on a request with the row closed, to COLACC on a page hit, and to PRECHG on a miss or when the row-low limit is near. PRECHG goes to REFCAS, ROWACT or IDLE. The remaining moves are ROWACT to COLACC, COLACC to COLPRE, COLPRE to IDLE, REFCAS to REFRAS and REFRAS to PRECHG.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The row address is req_addr[21:11] and must be on dram_addr when the row strobes fall. The column address is req_addr[10:0] and must be on dram_addr when the column strobes fall.
- R2: Both bits of dram_ras_n always carry the same value.
- R3: Before each row-strobe fall the row strobes are high for at least 4 cycles. Before a column strobe falls during an access, the row strobes are low for at least 2 cycles. Column strobes stay low for at least 2 cycles and high for at least 1 cycle between column cycles.
- R4: In a write, dram_cas_n[i] goes low only when req_be[i] is 1, where lane i is data bits 8i+7..8i. dram_we_n and dram_dq_oe are active whenever a column strobe is low, and byte lanes that are not enabled keep their stored value.
- R5: In a read, all four column strobes go low. The data is returned on rd_data with a rd_valid pulse that lasts exactly one cycle. A write is answered with a one-cycle wr_done pulse.
- R6: A request to the row that is already open completes (rd_valid or wr_done seen) 2 cycles after the acceptance edge, and the row strobes stay low.
- R7: A request to a different row while a row is open completes 8 cycles after acceptance: precharge, then row open, then column.
- R8: A request while no row is open completes 4 cycles after acceptance.
- R9: While ref_req is high, req_ready is low. A refresh drops the column strobes before the row strobes and answers with a one-cycle ref_ack, and no row is open afterwards.
- R10: The row strobes never stay low for RAS_MAX_CYC cycles or more, even under continuous page hits.
- R11: After reset all strobes are inactive, dram_dq_oe is 0, req_ready is 1 and rd_valid, wr_done and ref_ack are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address: row in bits 21:11, column in bits 10:0 |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for a write |
| req_ready | output | 1 | Request is taken on a clock edge where this and req_valid are both high |
| rd_valid | output | 1 | One-cycle pulse: rd_data is valid |
| rd_data | output | 32 | Read data |
| wr_done | output | 1 | One-cycle pulse: write finished |
| ref_req | input | 1 | Refresh request level |
| ref_ack | output | 1 | One-cycle pulse: refresh finished |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 2 | Row strobes, one per half array |
| dram_cas_n | output | 4 | Column strobes, one per byte lane |
| dram_we_n | output | 1 | Write strobe |
| dram_dq_out | output | 32 | Data driven toward the memory |
| dram_dq_oe | output | 1 | Enable for dram_dq_out |
| dram_dq_in | input | 32 | Data returned by the memory |

## Verification
The request is taken on the acceptance edge. The response pulse is due after a fixed number of clock edges: 2 for a page hit, 4 when no row is open and 8 for a row miss. The bench keeps its own record of which row it expects to be open, predicts that count before each request, counts edges after acceptance and samples the pulse on the falling clock. The following falling clock confirms that the pulse has ended. A behavioural memory in the bench decodes the strobes on every falling clock. It checks the minimum strobe intervals and the row-low limit each cycle, and refresh is checked by its acknowledge and by the order of the column and row strobe falls.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECHG,
        ST_ROWACT,
        ST_COLACC,
        ST_COLPRE,
        ST_REFCAS,
        ST_REFRAS
    } fpm_state_e;
endpackage

// File: rtl/fpm_row_tracker.sv
module fpm_row_tracker #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_en,
    input  logic             close_en,
    input  logic [ROW_W-1:0] load_row,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             row_open,
    output logic             page_hit
);
    logic [ROW_W-1:0] open_row;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_open <= 1'b0;
            open_row <= '0;
        end else if (close_en) begin
            row_open <= 1'b0;
        end else if (open_en) begin
            row_open <= 1'b1;
            open_row <= load_row;
        end
    end

    assign page_hit = row_open && (open_row == cmp_row);
endmodule

// File: rtl/fpm_ras_guard.sv
module fpm_ras_guard #(
    parameter int RAS_MAX_CYC = 10000,
    parameter int GUARD       = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_low,
    output logic near_limit
);
    localparam int CW    = $clog2(RAS_MAX_CYC + 1);
    localparam int LIMIT = RAS_MAX_CYC - GUARD;

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (!ras_low)
            low_cnt <= '0;
        else if (low_cnt != CW'(RAS_MAX_CYC))
            low_cnt <= low_cnt + 1'b1;
    end

    assign near_limit = (low_cnt >= CW'(LIMIT));
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int ADDR_W      = 22,
    parameter int ROW_W       = 11,
    parameter int DATA_W      = 32,
    parameter int RAS_BANKS   = 2,
    parameter int T_RP        = 4,
    parameter int T_RCD       = 2,
    parameter int T_CAS       = 2,
    parameter int T_CP        = 1,
    parameter int T_REF       = 6,
    parameter int RAS_MAX_CYC = 10000
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_valid,
    input  logic                                   req_write,
    input  logic [ADDR_W-1:0]                      req_addr,
    input  logic [DATA_W-1:0]                      req_wdata,
    input  logic [DATA_W/8-1:0]                    req_be,
    output logic                                   req_ready,
    output logic                                   rd_valid,
    output logic [DATA_W-1:0]                      rd_data,
    output logic                                   wr_done,
    input  logic                                   ref_req,
    output logic                                   ref_ack,
    output logic [((ROW_W > ADDR_W-ROW_W) ? ROW_W : ADDR_W-ROW_W)-1:0] dram_addr,
    output logic [RAS_BANKS-1:0]                   dram_ras_n,
    output logic [DATA_W/8-1:0]                    dram_cas_n,
    output logic                                   dram_we_n,
    output logic [DATA_W-1:0]                      dram_dq_out,
    output logic                                   dram_dq_oe,
    input  logic [DATA_W-1:0]                      dram_dq_in
);
    localparam int COL_W = ADDR_W - ROW_W;
    localparam int BUS_W = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int LANES = DATA_W / 8;
    localparam int CNT_W = 8;
    localparam int RUN_W = $clog2(RAS_MAX_CYC + 2);

    fpm_state_e       state, nxt;
    logic [CNT_W-1:0] cnt, dur;
    logic             req_pend, ref_pend, lat_write;
    logic [ROW_W-1:0] lat_row;
    logic [COL_W-1:0] lat_col;
    logic [LANES-1:0] lat_be;
    logic [DATA_W-1:0] lat_wdata;
    logic             take_req, take_ref, row_open, page_hit, near_limit, ras_on;

    fpm_row_tracker #(.ROW_W(ROW_W)) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_en  (state == ST_ROWACT),
        .close_en (state == ST_PRECHG),
        .load_row (lat_row),
        .cmp_row  (req_addr[ADDR_W-1:COL_W]),
        .row_open (row_open),
        .page_hit (page_hit)
    );

    fpm_ras_guard #(.RAS_MAX_CYC(RAS_MAX_CYC), .GUARD(8)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .ras_low    (ras_on),
        .near_limit (near_limit)
    );

    // next-state decision
    always_comb begin
        nxt      = state;
        take_req = 1'b0;
        take_ref = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (ref_req) begin
                    take_ref = 1'b1;
                    nxt = row_open ? ST_PRECHG : ST_REFCAS;
                end else if (req_valid) begin
                    take_req = 1'b1;
                    if (!row_open)                    nxt = ST_ROWACT;
                    else if (page_hit && !near_limit) nxt = ST_COLACC;
                    else                              nxt = ST_PRECHG;
                end else if (row_open && near_limit) begin
                    nxt = ST_PRECHG;
                end
            end
            ST_PRECHG: if (cnt == '0)
                nxt = ref_pend ? ST_REFCAS : (req_pend ? ST_ROWACT : ST_IDLE);
            ST_ROWACT: if (cnt == '0) nxt = ST_COLACC;
            ST_COLACC: if (cnt == '0) nxt = ST_COLPRE;
            ST_COLPRE: if (cnt == '0) nxt = ST_IDLE;
            ST_REFCAS: if (cnt == '0) nxt = ST_REFRAS;
            ST_REFRAS: if (cnt == '0) nxt = ST_PRECHG;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (nxt)
            ST_PRECHG: dur = CNT_W'(T_RP - 1);
            ST_ROWACT: dur = CNT_W'(T_RCD - 1);
            ST_COLACC: dur = CNT_W'(T_CAS - 1);
            ST_COLPRE: dur = CNT_W'(T_CP - 1);
            ST_REFRAS: dur = CNT_W'(T_REF - 1);
            default:   dur = '0;
        endcase
    end

    // state register, phase counter, request latches, response pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            req_pend  <= 1'b0;
            ref_pend  <= 1'b0;
            lat_write <= 1'b0;
            lat_row   <= '0;
            lat_col   <= '0;
            lat_be    <= '0;
            lat_wdata <= '0;
            rd_data   <= '0;
            rd_valid  <= 1'b0;
            wr_done   <= 1'b0;
            ref_ack   <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt != state)  cnt <= dur;
            else if (cnt != 0) cnt <= cnt - 1'b1;
            if (take_req) begin
                lat_write <= req_write;
                lat_row   <= req_addr[ADDR_W-1:COL_W];
                lat_col   <= req_addr[COL_W-1:0];
                lat_be    <= req_be;
                lat_wdata <= req_wdata;
                req_pend  <= (nxt == ST_PRECHG);
            end else if (state == ST_ROWACT) begin
                req_pend  <= 1'b0;
            end
            if (take_ref)                                    ref_pend <= 1'b1;
            else if (state == ST_REFRAS)                     ref_pend <= 1'b0;
            rd_valid <= (state == ST_COLACC) && (cnt == '0) && !lat_write;
            wr_done  <= (state == ST_COLACC) && (cnt == '0) &&  lat_write;
            ref_ack  <= (state == ST_REFRAS) && (cnt == '0);
            if ((state == ST_COLACC) && (cnt == '0) && !lat_write)
                rd_data <= dram_dq_in;
        end
    end

    // strobe and bus decode
    always_comb begin
        ras_on      = (state == ST_IDLE) ? row_open :
                      (state == ST_ROWACT) || (state == ST_COLACC) ||
                      (state == ST_COLPRE) || (state == ST_REFRAS);
        dram_ras_n  = {RAS_BANKS{!ras_on}};
        dram_cas_n  = '1;
        if (state == ST_COLACC)
            dram_cas_n = lat_write ? ~lat_be : '0;
        else if ((state == ST_REFCAS) || (state == ST_REFRAS))
            dram_cas_n = '0;
        dram_we_n   = !((state == ST_COLACC) && lat_write);
        dram_dq_oe  = (state == ST_COLACC) && lat_write;
        dram_dq_out = lat_wdata;
        dram_addr   = ((state == ST_ROWACT) && (cnt == CNT_W'(T_RCD - 1))) ?
                      BUS_W'(lat_row) : BUS_W'(lat_col);
        req_ready   = (state == ST_IDLE) && !ref_req;
    end

    // interval counters observed at the pins, for the assertions below
    logic                 any_cas_low;
    logic [RUN_W-1:0]     ras_hi_run, ras_lo_run, cas_hi_run, cas_lo_run;
    assign any_cas_low = ~&dram_cas_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_hi_run <= '1;
            ras_lo_run <= '0;
            cas_hi_run <= '1;
            cas_lo_run <= '0;
        end else begin
            if (dram_ras_n[0]) begin
                ras_lo_run <= '0;
                if (~&ras_hi_run) ras_hi_run <= ras_hi_run + 1'b1;
            end else begin
                ras_hi_run <= '0;
                if (~&ras_lo_run) ras_lo_run <= ras_lo_run + 1'b1;
            end
            if (!any_cas_low) begin
                cas_lo_run <= '0;
                if (~&cas_hi_run) cas_hi_run <= cas_hi_run + 1'b1;
            end else begin
                cas_hi_run <= '0;
                if (~&cas_lo_run) cas_lo_run <= cas_lo_run + 1'b1;
            end
        end
    end

    AST_RAS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_ras_n == '0) || (dram_ras_n == '1)); // R2
    AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n[0] && $past(dram_ras_n[0])) |-> (ras_hi_run >= RUN_W'(T_RP))); // R3
    AST_RAS_TO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        (any_cas_low && !$past(any_cas_low) && !dram_ras_n[0]) |-> (ras_lo_run >= RUN_W'(T_RCD))); // R3
    AST_CAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_cas_low && $past(any_cas_low)) |-> (cas_lo_run >= RUN_W'(T_CAS))); // R3
    AST_CAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        (any_cas_low && !$past(any_cas_low)) |-> (cas_hi_run >= RUN_W'(T_CP))); // R3
    AST_WRITE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> (dram_dq_oe && any_cas_low && !dram_ras_n[0])); // R4
    AST_READ_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n[0] && any_cas_low && dram_we_n) |-> (dram_cas_n == '0)); // R5
    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R5
    AST_REF_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |=> !ref_ack); // R9
    AST_RAS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        ras_lo_run < RUN_W'(RAS_MAX_CYC)); // R10
endmodule

// File: tb/fpm_dram_ctrl_test.sv
module fpm_dram_ctrl_test;
    localparam int RMAX = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid, req_write, req_ready, rd_valid, wr_done, ref_req, ref_ack;
    logic [21:0] req_addr;
    logic [31:0] req_wdata, rd_data, dram_dq_out;
    logic [31:0] dram_dq_in = '0;
    logic [3:0]  req_be, dram_cas_n;
    logic [10:0] dram_addr;
    logic [1:0]  dram_ras_n;
    logic        dram_we_n, dram_dq_oe;

    always #4 clk = ~clk;

    fpm_dram_ctrl #(.RAS_MAX_CYC(RMAX)) uut (.*);

    int n_cmp = 0, n_bad = 0;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // behavioural memory and strobe monitor
    logic [31:0] dmem [int];
    logic [31:0] smem [int];
    logic [10:0] m_row = '0, m_col = '0;
    int cbr_cnt = 0, row_falls = 0, lo_run = 0, lo_max = 0, hi_run = 100, clo_run = 0;
    logic pr_ras = 1'b1;
    logic [3:0] pr_cas = 4'hF;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(dram_ras_n[0] == dram_ras_n[1], "R2 strobe pair", dram_ras_n, {2{dram_ras_n[0]}});
            if (!dram_ras_n[0]) begin
                lo_run++;
                if (lo_run > lo_max) lo_max = lo_run;
            end else lo_run = 0;
            if (!dram_ras_n[0] && pr_ras) begin
                chk(hi_run >= 4, "R3 row precharge", hi_run, 4);
                if (dram_cas_n != 4'hF) cbr_cnt++;
                else begin m_row = dram_addr; row_falls++; end
            end
            if (!dram_ras_n[0] && !pr_ras && ((pr_cas & ~dram_cas_n) != 4'h0)) begin
                int key;
                chk(pr_cas == 4'hF, "R3 column precharge", pr_cas, 4'hF);
                chk(lo_run >= 3, "R3 row-to-column delay", lo_run - 1, 2);
                m_col = dram_addr;
                key = int'({m_row, m_col});
                if (!dmem.exists(key)) dmem[key] = '0;
                if (!dram_we_n) begin
                    chk(dram_dq_oe, "R4 output enable", dram_dq_oe, 1);
                    for (int l = 0; l < 4; l++)
                        if (!dram_cas_n[l]) dmem[key][8*l +: 8] = dram_dq_out[8*l +: 8];
                end else dram_dq_in = dmem[key];
            end
            if ((pr_cas != 4'hF) && (dram_cas_n == 4'hF))
                chk(clo_run >= 2, "R3 column width", clo_run, 2);
            if (dram_cas_n != 4'hF) clo_run++; else clo_run = 0;
            if (dram_ras_n[0]) hi_run++; else hi_run = 0;
            pr_ras = dram_ras_n[0];
            pr_cas = dram_cas_n;
        end
    end

    bit          exp_open = 1'b0;
    logic [10:0] exp_row  = '0;

    task automatic do_req(input bit wr, input logic [21:0] a, input logic [31:0] d,
                          input logic [3:0] be, input bit chk_lat);
        int lat, exp_lat, key;
        logic [31:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        exp_lat = !exp_open ? 4 : ((a[21:11] == exp_row) ? 2 : 8);
        @(posedge clk);
        #1 req_valid = 1'b0;
        lat = 0;
        do begin
            @(posedge clk); lat++;
            @(negedge clk);
        end while (!(wr ? wr_done : rd_valid) && lat < 60);
        if (chk_lat)
            chk(lat == exp_lat, exp_lat == 4 ? "R8 closed-row latency" :
                (exp_lat == 2 ? "R6 page-hit latency" : "R7 row-miss latency"), lat, exp_lat);
        chk({m_row, m_col} == a, "R1 row/column split", {m_row, m_col}, a);
        key = int'(a);
        e = smem.exists(key) ? smem[key] : '0;
        if (wr) begin
            for (int l = 0; l < 4; l++) if (be[l]) e[8*l +: 8] = d[8*l +: 8];
            smem[key] = e;
        end else begin
            chk(rd_data == e, "R4/R5 read data", rd_data, e);
        end
        @(negedge clk);
        chk(!(wr ? wr_done : rd_valid), "R5 single-cycle pulse", wr ? wr_done : rd_valid, 0);
        exp_open = 1'b1;
        exp_row  = a[21:11];
    endtask

    task automatic do_ref();
        int c0, t;
        c0 = cbr_cnt;
        @(negedge clk);
        ref_req = 1'b1;
        #1 chk(!req_ready, "R9 ready low during refresh", req_ready, 0);
        t = 0;
        while (!ref_ack && t < 60) begin @(negedge clk); t++; end
        ref_req = 1'b0;
        chk(ref_ack, "R9 acknowledge", ref_ack, 1);
        chk(cbr_cnt == c0 + 1, "R9 column-before-row order", cbr_cnt - c0, 1);
        @(negedge clk);
        chk(!ref_ack, "R9 acknowledge pulse", ref_ack, 0);
        exp_open = 1'b0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int rf0;
        req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_be = '0; ref_req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dram_ras_n == 2'b11, "R11 reset row strobes", dram_ras_n, 3);
        chk(dram_cas_n == 4'hF, "R11 reset column strobes", dram_cas_n, 15);
        chk(dram_we_n && !dram_dq_oe, "R11 reset write/enable", {dram_we_n, dram_dq_oe}, 2);
        chk(req_ready, "R11 reset ready", req_ready, 1);
        chk(!rd_valid && !wr_done && !ref_ack, "R11 reset pulses", {rd_valid, wr_done, ref_ack}, 0);

        do_req(1, {11'd5, 11'd10}, 32'h11223344, 4'hF, 1);
        do_req(0, {11'd5, 11'd10}, '0, 4'h0, 1);
        do_req(1, {11'd5, 11'd11}, 32'hAABBCCDD, 4'b0101, 1);
        do_req(0, {11'd5, 11'd11}, '0, 4'h0, 1);
        do_req(1, {11'd5, 11'd10}, 32'hFFFFFFFF, 4'b1000, 1);
        do_req(0, {11'd5, 11'd10}, '0, 4'h0, 1);
        do_req(0, {11'd9, 11'd10}, '0, 4'h0, 1);
        for (int i = 0; i < 6; i++) begin
            do_req(1, {11'(100 + 3 * i), 11'(i * 97)}, 32'h5A000000 + i * 32'h01010101, 4'hF, 1);
            do_req(1, {11'(100 + 3 * i), 11'(i * 97)}, 32'h0000C300 + i, 4'b0011, 1);
            do_req(0, {11'(100 + 3 * i), 11'(i * 97)}, '0, 4'h0, 1);
        end
        do_ref();
        do_req(0, {11'd5, 11'd10}, '0, 4'h0, 1);

        rf0 = row_falls;
        for (int i = 0; i < 15; i++) begin
            do_req(1, {11'd7, 11'(i)}, 32'hC0DE0000 + i, 4'hF, 0);
            do_req(0, {11'd7, 11'(i)}, '0, 4'h0, 0);
        end
        chk(lo_max < RMAX, "R10 longest row-low run", lo_max, RMAX - 1);
        chk(row_falls - rf0 >= 2, "R10 row reopened under hits", row_falls - rf0, 2);
        do_ref();
        do_req(0, {11'd7, 11'd3}, '0, 4'h0, 1);
        report();
    end
endmodule